// File: doc/BRIEF.md
# Multi-Mode SAR Conversion Sequencer

This block is the digital half of an 8-bit, four-input successive-approximation converter. It picks which analog input the external multiplexer presents, steps a trial code out to an external DAC one bit per clock, and reads a single comparator bit back to decide each bit. Every finished conversion lands in one of four result registers. Which register is used, which input comes next, and when the completion pulse fires all depend on the sequencing mode latched at the start request.

Software or a host controller sets a channel-enable mask and a 3-bit mode code, then pulses a start request. Single modes end by themselves. Continuous modes keep converting until a stop request arrives. The conversion in flight always completes first.

The controller has three states. `ST_IDLE` waits for an accepted start and moves to `ST_TRIAL`, latching the mode and mask. `ST_TRIAL` runs the eight bit trials and moves to `ST_COMMIT` after the last one. `ST_COMMIT` writes the result and then does one of two things. It goes back to `ST_TRIAL` for the next conversion of a sequence. It goes to `ST_IDLE` when the sequence is over or a stop is pending.

Top module: `adc_seq_ctrl`

## Requirements
- R1: The mode code `mode_bits` = {burst, scc, scan} is decoded against the number of set bits in `chan_mask`.
  - 000 with at least one bit selects single step.
  - 001 with one bit selects fixed single; 001 with two or more bits selects scan single.
  - 010 with one bit selects fixed loop; 010 with exactly two bits selects dual loop.
  - 100 with at least one bit selects scan loop.
  - Every other code or mask is invalid, and its start request is ignored: no conversion runs and `busy` stays low.
- R2: Each conversion runs 8 trials from MSB to LSB. A trial drives `dac_code` = kept bits OR trial bit and keeps the trial bit only when `cmp_ge` is 1. The first trial code is 0x80, `dac_code` is 0 while idle, and the stored result equals the input code, including 0x00 and 0xFF.
- R3: A conversion lasts 9 cycles: 8 trial cycles plus 1 commit cycle. `busy` rises on the edge that accepts the start and falls on the edge after the last commit, which is also the edge that shows the new result and the pulse. `mux_sel` (binary channel index) is held through every trial.
- R4: Fixed single converts the one enabled input k once, writes `results[k]` (bits 8k+7:8k), and raises one pulse.
- R5: Scan single converts every enabled input once, from index 0 upward. Input k's result goes to `results[k]`, and one pulse follows the last conversion.
- R6: Scan loop repeats the ascending pass, writing input k to `results[k]`. It pulses after each pass and restarts from the lowest enabled input.
- R7: Fixed loop converts the one enabled input repeatedly. Results fill registers 0, 1, 2, 3 and then wrap, with a pulse after each write to register 3.
- R8: Dual loop alternates lower-index input then higher-index input. Results go to registers 0, 1, 2, 3 in that order, with a pulse after each group of four.
- R9: Single step converts one input per start. It starts from the first enabled input at or above a step pointer, searching circularly upward, and then sets the pointer to that index plus 1 (mod 4). The pointer is 0 after reset and is kept across starts. Each step raises one pulse.
- R10: A stop request while busy lets the conversion in flight finish and then returns to idle. A stop request while idle has no effect.
- R11: A start request while busy is ignored. Mode and mask are latched at start, so later changes do not alter a running sequence.
- R12: After reset, `busy`, `irq_flag`, `dac_code`, `mux_sel` and all results are 0.
- R13: `irq_flag` is a one-cycle pulse that follows a busy cycle. At most one result register changes per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the trial rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_mask | input | NCH | Channel-enable mask |
| mode_bits | input | 3 | Mode code {burst, scc, scan} |
| start_req | input | 1 | Start request, sampled while idle |
| stop_req | input | 1 | Stop request for the running sequence |
| cmp_ge | input | 1 | Comparator: input at or above `dac_code` |
| mux_sel | output | $clog2(NCH) | Selected input index |
| dac_code | output | DW | Trial code for the external DAC |
| results | output | NCH*DW | Result registers, register k at bits 8k+7:8k |
| busy | output | 1 | Sequence running |
| irq_flag | output | 1 | One-cycle completion pulse |

## Verification
The assertions check the following on every cycle:
- the idle DAC code is zero;
- the first trial code is the MSB;
- the channel select stays steady during trials;
- the completion pulse lasts one cycle and follows busy;
- no more than one result register changes at a time;
- a start request in mid-conversion never ends busy.

Only the bench scenarios can show the mode-dependent behaviour:
- channel order and register placement in each mode;
- conversion counts after a stop;
- the step pointer's circular walk;
- that invalid codes start nothing.

The bench does this by sweeping every mask across each mode and comparing against an arithmetic input model.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    // Controller states
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_TRIAL  = 2'd1,
        ST_COMMIT = 2'd2
    } seq_state_e;

    // Resolved sequencing modes
    typedef enum logic [2:0] {
        MD_NONE      = 3'd0,
        MD_STEP      = 3'd1,
        MD_FIX_ONE   = 3'd2,
        MD_SCAN_ONE  = 3'd3,
        MD_FIX_LOOP  = 3'd4,
        MD_DUAL_LOOP = 3'd5,
        MD_SCAN_LOOP = 3'd6
    } seq_mode_e;

endpackage

// File: rtl/adc_seq_chan_pick.sv
// Channel search helpers: lowest and highest enabled input, next enabled
// input above the current one, and the first enabled input found by a
// circular upward search from a start index.
module adc_seq_chan_pick #(
    parameter int NCH = 4
) (
    input  logic [NCH-1:0]          mask,
    input  logic [$clog2(NCH)-1:0]  cur,
    input  logic [$clog2(NCH)-1:0]  from,
    output logic [$clog2(NCH)-1:0]  lowest,
    output logic [$clog2(NCH)-1:0]  highest,
    output logic [$clog2(NCH)-1:0]  above_idx,
    output logic                    above_ok,
    output logic [$clog2(NCH)-1:0]  wrap_idx,
    output logic [$clog2(NCH):0]    pop
);
    localparam int CW = $clog2(NCH);

    always_comb begin
        lowest    = '0;
        highest   = '0;
        above_idx = '0;
        above_ok  = 1'b0;
        wrap_idx  = '0;
        pop       = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (mask[i]) lowest = CW'(i);
        end
        for (int i = 0; i < NCH; i++) begin
            if (mask[i]) begin
                highest = CW'(i);
                pop     = pop + (CW+1)'(1);
            end
        end
        for (int i = NCH - 1; i >= 0; i--) begin
            if (mask[i] && (i > int'(cur))) begin
                above_idx = CW'(i);
                above_ok  = 1'b1;
            end
        end
        for (int k = NCH - 1; k >= 0; k--) begin
            if (mask[(int'(from) + k) % NCH]) wrap_idx = CW'((int'(from) + k) % NCH);
        end
    end

endmodule

// File: rtl/adc_seq_mode_dec.sv
// Resolves the 3-bit mode code plus the enabled-input count into a mode.
module adc_seq_mode_dec
    import adc_seq_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic [2:0]               mode_bits,
    input  logic [$clog2(NCH):0]     pop,
    output seq_mode_e                mode
);
    localparam int PW = $clog2(NCH) + 1;

    always_comb begin
        mode = MD_NONE;
        unique case (mode_bits)
            3'b000: mode = (pop != '0) ? MD_STEP : MD_NONE;
            3'b001: begin
                if (pop == PW'(1))     mode = MD_FIX_ONE;
                else if (pop > PW'(1)) mode = MD_SCAN_ONE;
            end
            3'b010: begin
                if (pop == PW'(1))      mode = MD_FIX_LOOP;
                else if (pop == PW'(2)) mode = MD_DUAL_LOOP;
            end
            3'b100: mode = (pop != '0) ? MD_SCAN_LOOP : MD_NONE;
            default: mode = MD_NONE;
        endcase
    end

endmodule

// File: rtl/adc_seq_sar.sv
// Bit-trial engine: one trial per clock, MSB first.
module adc_seq_sar #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          run,
    input  logic          cmp_ge,
    output logic [DW-1:0] dac_code,
    output logic          last,
    output logic [DW-1:0] result
);
    logic [DW-1:0] acc_q;
    logic [DW-1:0] trial_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q   <= '0;
            trial_q <= '0;
        end else if (load) begin
            acc_q   <= '0;
            trial_q <= {1'b1, {(DW-1){1'b0}}};
        end else if (run) begin
            if (cmp_ge) acc_q <= acc_q | trial_q;
            trial_q <= trial_q >> 1;
        end
    end

    assign dac_code = run ? (acc_q | trial_q) : '0;
    assign last     = trial_q[0];
    assign result   = acc_q;

endmodule

// File: rtl/adc_seq_ctrl.sv
// Multi-mode conversion sequencer top.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NCH-1:0]              chan_mask,
    input  logic [2:0]                  mode_bits,
    input  logic                        start_req,
    input  logic                        stop_req,
    input  logic                        cmp_ge,
    output logic [$clog2(NCH)-1:0]      mux_sel,
    output logic [DW-1:0]               dac_code,
    output logic [NCH-1:0][DW-1:0]      results,
    output logic                        busy,
    output logic                        irq_flag
);
    localparam int CW = $clog2(NCH);
    localparam logic [CW-1:0] LAST_SLOT = CW'(NCH - 1);

    seq_state_e st_q, st_d;
    seq_mode_e  mode_q, mode_live;

    logic [NCH-1:0]          mask_q, mask_use;
    logic [CW-1:0]           ch_q, ch_d, cnt_q, step_q, dest, nxt;
    logic [NCH-1:0][DW-1:0]  res_q;
    logic                    stop_pend_q, stop_now;
    logic                    irq_q, irq_d;
    logic                    load, commit, cont;

    logic [CW-1:0] lowest, highest, above_idx, wrap_idx;
    logic          above_ok;
    logic [CW:0]   pop;
    logic          sar_last;
    logic [DW-1:0] sar_result;

    // While idle the live mask is searched; once running, the latched one.
    assign mask_use = (st_q == ST_IDLE) ? chan_mask : mask_q;

    adc_seq_chan_pick #(.NCH(NCH)) pick_i (
        .mask      (mask_use),
        .cur       (ch_q),
        .from      (step_q),
        .lowest    (lowest),
        .highest   (highest),
        .above_idx (above_idx),
        .above_ok  (above_ok),
        .wrap_idx  (wrap_idx),
        .pop       (pop)
    );

    adc_seq_mode_dec #(.NCH(NCH)) dec_i (
        .mode_bits (mode_bits),
        .pop       (pop),
        .mode      (mode_live)
    );

    adc_seq_sar #(.DW(DW)) sar_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .run      (st_q == ST_TRIAL),
        .cmp_ge   (cmp_ge),
        .dac_code (dac_code),
        .last     (sar_last),
        .result   (sar_result)
    );

    // Next state and per-cycle controls
    always_comb begin
        st_d     = st_q;
        ch_d     = ch_q;
        load     = 1'b0;
        commit   = 1'b0;
        irq_d    = 1'b0;
        cont     = 1'b0;
        dest     = ch_q;
        nxt      = ch_q;
        stop_now = stop_pend_q | stop_req;
        unique case (st_q)
            ST_IDLE: begin
                if (start_req && (mode_live != MD_NONE)) begin
                    load = 1'b1;
                    st_d = ST_TRIAL;
                    ch_d = (mode_live == MD_STEP) ? wrap_idx : lowest;
                end
            end
            ST_TRIAL: begin
                if (sar_last) st_d = ST_COMMIT;
            end
            ST_COMMIT: begin
                commit = 1'b1;
                unique case (mode_q)
                    MD_FIX_LOOP: begin
                        dest  = cnt_q;
                        irq_d = (cnt_q == LAST_SLOT);
                        cont  = 1'b1;
                    end
                    MD_DUAL_LOOP: begin
                        dest  = cnt_q;
                        irq_d = (cnt_q == LAST_SLOT);
                        cont  = 1'b1;
                        nxt   = cnt_q[0] ? lowest : highest;
                    end
                    MD_SCAN_ONE: begin
                        irq_d = !above_ok;
                        cont  = above_ok;
                        nxt   = above_idx;
                    end
                    MD_SCAN_LOOP: begin
                        irq_d = !above_ok;
                        cont  = 1'b1;
                        nxt   = above_ok ? above_idx : lowest;
                    end
                    default: irq_d = 1'b1;
                endcase
                if (cont && !stop_now) begin
                    load = 1'b1;
                    st_d = ST_TRIAL;
                    ch_d = nxt;
                end else begin
                    st_d = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Sequencing data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q      <= MD_NONE;
            mask_q      <= '0;
            ch_q        <= '0;
            cnt_q       <= '0;
            step_q      <= '0;
            res_q       <= '0;
            irq_q       <= 1'b0;
            stop_pend_q <= 1'b0;
        end else begin
            ch_q  <= ch_d;
            irq_q <= irq_d;
            if ((st_q == ST_IDLE) && load) begin
                mode_q <= mode_live;
                mask_q <= chan_mask;
                cnt_q  <= '0;
            end else if (commit) begin
                cnt_q <= cnt_q + CW'(1);
            end
            if (commit) res_q[dest] <= sar_result;
            if (commit && (mode_q == MD_STEP)) step_q <= ch_q + CW'(1);
            if (st_d == ST_IDLE)                     stop_pend_q <= 1'b0;
            else if (stop_req && (st_q != ST_IDLE))  stop_pend_q <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        busy     = (st_q != ST_IDLE);
        mux_sel  = ch_q;
        results  = res_q;
        irq_flag = irq_q;
    end

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
// Property checker bound to the sequencer top.
module adc_seq_ctrl_chk #(
    parameter int NCH = 4,
    parameter int DW  = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start_req,
    input logic [$clog2(NCH)-1:0]  mux_sel,
    input logic [DW-1:0]           dac_code,
    input logic [NCH-1:0][DW-1:0]  results,
    input logic                    busy,
    input logic                    irq_flag
);
    localparam logic [DW-1:0] MSB_CODE = DW'(1) << (DW - 1);

    logic [NCH-1:0][DW-1:0] prev_res;
    logic [NCH-1:0]         chg;
    logic                   mid_trial;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_res <= '0;
        else        prev_res <= results;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_chg
        assign chg[g] = (results[g] != prev_res[g]);
    end

    assign mid_trial = busy && (dac_code != '0) && (dac_code != MSB_CODE);

    p_idle_dac_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (dac_code == '0));

    p_first_trial_msb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (dac_code == MSB_CODE));

    p_mux_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mid_trial |-> $stable(mux_sel));

    p_start_busy_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mid_trial && start_req) |=> busy);

    p_irq_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
        irq_flag |=> !irq_flag);

    p_irq_after_busy_r13: assert property (@(posedge clk) disable iff (!rst_n)
        irq_flag |-> $past(busy));

    p_one_write_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(chg) <= 1);

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.NCH(NCH), .DW(DW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (start_req),
    .mux_sel   (mux_sel),
    .dac_code  (dac_code),
    .results   (results),
    .busy      (busy),
    .irq_flag  (irq_flag)
);

// File: tb/adc_seq_ctrl_tb_top.sv
module adc_seq_ctrl_tb_top;
    localparam int NCH = 4;
    localparam int DW  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [3:0]      chan_mask = '0;
    logic [2:0]      mode_bits = '0;
    logic            start_req = 1'b0;
    logic            stop_req  = 1'b0;
    logic            cmp_ge;
    logic [1:0]      mux_sel;
    logic [7:0]      dac_code;
    logic [3:0][7:0] results;
    logic            busy, irq_flag;

    int n_cmp = 0;
    int n_bad = 0;
    int nconv = 0;
    int irq_cnt = 0;
    int log_ch [0:1023];
    logic [8:0] fixed_val = '0;
    logic [7:0] exp_res [0:3];
    int step_ptr_m = 0;

    // Analog input model: a fixed code when fixed_val[8] is set, else an
    // arithmetic code from the input index and the conversion number.
    function automatic logic [7:0] aval(int ch, int n, logic [8:0] fv);
        if (fv[8]) return fv[7:0];
        return 8'(ch * 77 + n * 41 + 9);
    endfunction

    always_comb cmp_ge = (aval(int'(mux_sel), nconv, fixed_val) >= dac_code);

    adc_seq_ctrl #(.NCH(NCH), .DW(DW)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .chan_mask (chan_mask),
        .mode_bits (mode_bits),
        .start_req (start_req),
        .stop_req  (stop_req),
        .cmp_ge    (cmp_ge),
        .mux_sel   (mux_sel),
        .dac_code  (dac_code),
        .results   (results),
        .busy      (busy),
        .irq_flag  (irq_flag)
    );

    // Conversion and pulse logger: the first trial shows code 0x80
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy && dac_code == 8'h80 && nconv < 1023) begin
                nconv = nconv + 1;
                log_ch[nconv] = int'(mux_sel);
            end
            if (irq_flag) irq_cnt = irq_cnt + 1;
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic pulse_start(logic [2:0] mb, logic [3:0] m);
        mode_bits = mb;
        chan_mask = m;
        start_req = 1'b1;
        tick();
        start_req = 1'b0;
    endtask

    task automatic wait_idle(output int cyc);
        int guard = 0;
        cyc = 0;
        while (busy && guard < 5000) begin
            cyc++;
            guard++;
            tick();
        end
        if (guard >= 5000) chk("R10 wait for idle timed out", 1, 0);
    endtask

    task automatic check_regs(string tag);
        for (int r = 0; r < 4; r++) chk({tag, " result register"}, int'(results[r]), int'(exp_res[r]));
    endtask

    function automatic int popc(logic [3:0] m);
        int c = 0;
        for (int i = 0; i < 4; i++) if (m[i]) c++;
        return c;
    endfunction

    function automatic int nth_set(logic [3:0] m, int n);
        int c = 0;
        for (int i = 0; i < 4; i++) begin
            if (m[i]) begin
                if (c == n) return i;
                c++;
            end
        end
        return 0;
    endfunction

    // Single, scan-single and single-step runs
    task automatic do_single(string tag, logic [2:0] mb, logic [3:0] m);
        int base = nconv;
        int ic = irq_cnt;
        int cyc;
        int n_exp = 0;
        int exp_ch [0:3];
        if (mb == 3'b000) begin
            for (int k = 3; k >= 0; k--) if (m[(step_ptr_m + k) % 4]) exp_ch[0] = (step_ptr_m + k) % 4;
            n_exp = 1;
            step_ptr_m = (exp_ch[0] + 1) % 4;
        end else begin
            for (int i = 0; i < 4; i++) if (m[i]) begin exp_ch[n_exp] = i; n_exp++; end
        end
        pulse_start(mb, m);
        wait_idle(cyc);
        chk({tag, " R3 busy cycles"}, cyc, 9 * n_exp);
        chk({tag, " conversion count"}, nconv - base, n_exp);
        for (int i = 0; i < n_exp; i++) begin
            chk({tag, " channel order"}, log_ch[base + i + 1], exp_ch[i]);
            exp_res[exp_ch[i]] = aval(exp_ch[i], base + i + 1, fixed_val);
        end
        check_regs(tag);
        chk({tag, " pulse count"}, irq_cnt - ic, 1);
    endtask

    // Continuous runs, stopped after k pulses
    task automatic do_loop(string tag, logic [2:0] mb, logic [3:0] m, int k, bit inject);
        int base = nconv;
        int ic = irq_cnt;
        int cyc, n, p, ch, dst, guard;
        int exp_irq = 0;
        bit rot = (mb == 3'b010);
        bit dual = rot && (popc(m) == 2);
        p = rot ? 4 : popc(m);
        pulse_start(mb, m);
        if (inject) begin
            repeat (3) tick();
            pulse_start(3'b001, 4'b0001);   // R11: ignored while busy
        end
        guard = 0;
        while (irq_cnt < ic + k && guard < 5000) begin guard++; tick(); end
        stop_req = 1'b1;
        tick();
        stop_req = 1'b0;
        wait_idle(cyc);
        n = nconv - base;
        chk({tag, " R10 conversions after stop"}, n, p * k + 1);
        if (n > 64) n = 64;
        for (int i = 0; i < n; i++) begin
            if (dual)     ch = (i % 2) ? nth_set(m, 1) : nth_set(m, 0);
            else if (rot) ch = nth_set(m, 0);
            else          ch = nth_set(m, i % p);
            dst = rot ? (i % 4) : ch;
            if ((i % p) == p - 1) exp_irq++;
            chk({tag, " channel order"}, log_ch[base + i + 1], ch);
            exp_res[dst] = aval(ch, base + i + 1, fixed_val);
        end
        check_regs(tag);
        chk({tag, " pulse count"}, irq_cnt - ic, exp_irq);
    endtask

    task automatic do_invalid(logic [2:0] mb, logic [3:0] m);
        int base = nconv;
        int seen_busy = 0;
        pulse_start(mb, m);
        repeat (12) begin
            if (busy) seen_busy++;
            tick();
        end
        chk("R1 invalid start busy", seen_busy, 0);
        chk("R1 invalid start conversions", nconv - base, 0);
        check_regs("R1 invalid");
    endtask

    initial begin
        int base;
        for (int r = 0; r < 4; r++) exp_res[r] = 8'h00;
        repeat (3) tick();
        // R12: reset state
        chk("R12 busy in reset", int'(busy), 0);
        chk("R12 irq in reset", int'(irq_flag), 0);
        chk("R12 dac in reset", int'(dac_code), 0);
        chk("R12 mux in reset", int'(mux_sel), 0);
        check_regs("R12");
        rst_n = 1'b1;
        tick();
        chk("R12 busy after reset", int'(busy), 0);

        // R2: extreme input codes
        fixed_val = 9'h100;
        do_single("R2 zero input", 3'b001, 4'b0001);
        fixed_val = 9'h1FF;
        do_single("R2 full input", 3'b001, 4'b1000);
        fixed_val = 9'h000;

        // R4: fixed single on every input
        for (int i = 0; i < 4; i++) do_single("R4", 3'b001, 4'(1 << i));

        // R5: scan single on every multi-bit mask
        for (int m = 1; m < 16; m++) if (popc(4'(m)) > 1) do_single("R5", 3'b001, 4'(m));

        // R9: single step walk, then every mask
        repeat (3) do_single("R9 walk", 3'b000, 4'b1010);
        for (int m = 1; m < 16; m++) do_single("R9 sweep", 3'b000, 4'(m));

        // R1: invalid codes and masks
        do_invalid(3'b011, 4'b1111);
        do_invalid(3'b101, 4'b1111);
        do_invalid(3'b110, 4'b0011);
        do_invalid(3'b111, 4'b0001);
        do_invalid(3'b001, 4'b0000);
        do_invalid(3'b000, 4'b0000);
        do_invalid(3'b100, 4'b0000);
        do_invalid(3'b010, 4'b0111);
        do_invalid(3'b010, 4'b1111);
        do_invalid(3'b010, 4'b0000);

        // R7: fixed loop
        do_loop("R7", 3'b010, 4'b0100, 2, 1'b0);
        do_loop("R7", 3'b010, 4'b0001, 1, 1'b0);

        // R8: dual loop on all pairs
        for (int m = 1; m < 16; m++) if (popc(4'(m)) == 2) do_loop("R8", 3'b010, 4'(m), 1, 1'b0);

        // R6: scan loop, with a start and a mask change while busy (R11)
        do_loop("R6 R11", 3'b100, 4'b1111, 2, 1'b1);
        do_loop("R6", 3'b100, 4'b1001, 2, 1'b0);
        do_loop("R6", 3'b100, 4'b0100, 2, 1'b0);

        // R10: stop while idle has no effect
        base = nconv;
        stop_req = 1'b1;
        tick();
        stop_req = 1'b0;
        repeat (3) tick();
        chk("R10 idle stop busy", int'(busy), 0);
        chk("R10 idle stop conversions", nconv - base, 0);
        do_single("R10 after idle stop", 3'b001, 4'b0110);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule